// File: doc/BRIEF.md
# PCM Frame Fill Sequencer

This block paces the loading of PCM samples into the input sample RAM of a two-stage frame encoder. A start pulse launches a stream of a programmed number of frames. The block then raises a DMA request, counts accepted sample writes, and starts the first encoder stage once a fill is complete. Each later fill begins when the first stage signals that it has released the input buffer. The fill does not wait for the buffer to drain. The first stage of one frame therefore overlaps the second stage of the frame before it.

The first fill of a stream is double-sized, so the first stage has look-ahead data. After the last real frame, one extra frame is fed, and a marker output tells the DMA side to supply zeros for it. That frame flushes the last real frame through the second stage. A done flag reports that the pipeline has drained. The encoder arithmetic, the RAM and the DMA engine are outside this block.

Top module: `pcm_fill_seq`

## Requirements
- R1: While reset is held low, `dma_req_o`, `zero_frame_o`, `s1_start_o`, `s2_start_o` and `done_o` are low on the following cycle.
- R2: A start pulse accepted while idle raises `dma_req_o` on the next cycle. The first fill then takes exactly FIRST_FILL (default 2048) accepted writes.
- R3: `dma_req_o` falls in the cycle right after the clock edge that accepted the last sample of a fill.
- R4: `s1_start_o` is a one-cycle pulse. It is issued only when four conditions hold: the fill for that job is complete, the first stage has finished its previous job, no first-stage result is still waiting for the second stage, and no DMA request is active.
- R5: Each buffer release by a busy first stage on jobs 0 to N-1 starts a refill of exactly REFILL (default 1024) accepted writes, where N is the programmed frame count.
- R6: The release issued during job N raises no request, so a stream has exactly N+1 fills.
- R7: `s2_start_o` is a one-cycle pulse. It is issued only for a finished first-stage job and only when the second stage is idle. The second stage may run while the first stage works on the next job.
- R8: Over one stream, each stage is started exactly N+1 times, for jobs 0 to N.
- R9: `zero_frame_o` is high exactly while the request for the fill of job N is active, and never without a request.
- R10: `done_o` rises when the second stage finishes job N. It stays high with no requests or stage starts until the next start pulse, which clears it.
- R11: A start pulse while a stream is running is ignored, including a different frame count on `frame_cnt_i`.
- R12: A write strobe while `dma_req_o` is low is not counted toward any fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start-of-stream pulse |
| frame_cnt_i | input | FRAME_W | Number of real frames N (at least 1), latched at start |
| dma_req_o | output | 1 | Sample DMA request |
| sample_wr_i | input | 1 | Sample write strobe; a write is accepted when the request is high |
| zero_frame_o | output | 1 | The current fill is the flush frame and must be zeros |
| s1_start_o | output | 1 | First-stage start pulse |
| s1_release_i | input | 1 | First stage has released the input buffer |
| s1_done_i | input | 1 | First stage finished its job |
| s2_start_o | output | 1 | Second-stage start pulse |
| s2_done_i | input | 1 | Second stage finished its job |
| done_o | output | 1 | Stream fully drained |

## Verification
The properties assume that each engine answers a start with exactly one done pulse, at least one cycle later. They also assume that the first stage issues its release once per job, between its start and its done, and that no done pulse arrives while the engine is idle. The bench engine models follow exactly this protocol, with a different release delay, completion delay and second-stage latency in each stream. The DMA model drives the write strobe from a pseudo-random pattern with no regard to the request. This places stray writes between fills without breaking any stage assumption.

// File: rtl/pcm_fill_pkg.sv
// Shared types for the PCM fill sequencer.
package pcm_fill_pkg;
    // Which fill length to load when the sample counter is armed.
    typedef enum logic {
        FILL_SHORT = 1'b0,
        FILL_LONG  = 1'b1
    } fill_len_e;
endpackage

// File: rtl/pcm_fill_counter.sv
// Sample fill counter: when armed, it holds a request open until the selected
// number of samples has been accepted. It then flags the buffer as full until
// the fill is consumed.
// Assumes: REFILL <= FIRST_FILL; arm_i is only pulsed while no fill is active.
module pcm_fill_counter
    import pcm_fill_pkg::*;
#(
    parameter int FIRST_FILL = 2048,
    parameter int REFILL     = 1024
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      arm_i,
    input  fill_len_e len_i,
    input  logic      wr_i,
    input  logic      consume_i,
    output logic      req_o,
    output logic      full_o
);
    localparam int CNT_W = $clog2(FIRST_FILL + 1);
    localparam logic [CNT_W-1:0] LONG_LEN  = CNT_W'(FIRST_FILL);
    localparam logic [CNT_W-1:0] SHORT_LEN = CNT_W'(REFILL);

    logic [CNT_W-1:0] remain_q;
    logic             full_q;
    logic             accept;

    // A write counts only while samples are still owed.
    assign accept = (remain_q != '0) && wr_i;

    // Remaining-sample counter: loaded on arm, decremented per accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (arm_i) begin
            remain_q <= (len_i == FILL_LONG) ? LONG_LEN : SHORT_LEN;
        end else if (accept) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end

    // Buffer-full flag: set by the last sample, cleared when the stage consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
        end else if (arm_i) begin
            full_q <= 1'b0;
        end else if (accept && (remain_q == CNT_W'(1))) begin
            full_q <= 1'b1;
        end else if (consume_i) begin
            full_q <= 1'b0;
        end
    end

    assign req_o  = (remain_q != '0);
    assign full_o = full_q;
endmodule

// File: rtl/pcm_stage_tracker.sv
// Stage handshake tracker: turns a launch decision into a registered one-cycle
// start pulse, holds a busy flag until the engine's done, and flags the
// accepted completion.
// Assumes: launch_i is only raised while busy_o is low; done_i only while busy.
module pcm_stage_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic launch_i,
    input  logic done_i,
    output logic start_o,
    output logic busy_o,
    output logic fin_o
);
    logic start_q;
    logic busy_q;

    // Start pulse register: one cycle per launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
        end else begin
            start_q <= launch_i && !busy_q;
        end
    end

    // Busy flag: set at launch, dropped when the engine reports completion.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            busy_q <= 1'b0;
        end else if (launch_i) begin
            busy_q <= 1'b1;
        end else if (done_i) begin
            busy_q <= 1'b0;
        end
    end

    assign start_o = start_q;
    assign busy_o  = busy_q;
    assign fin_o   = busy_q && done_i;
endmodule

// File: rtl/pcm_fill_seq.sv
// PCM frame fill sequencer (top): runs a stream of N real frames plus one
// zero flush frame through a two-stage encoder. Job 0 gets a double-sized
// fill. Each release by the first stage triggers the fill for the next job,
// up to job N. The first stage starts a job once its fill is done and the
// previous first-stage result has been handed to the second stage.
// Assumes: frame_cnt_i >= 1; engines follow a start/done protocol with one
// release per first-stage job.
module pcm_fill_seq
    import pcm_fill_pkg::*;
#(
    parameter int FIRST_FILL = 2048,
    parameter int REFILL     = 1024,
    parameter int FRAME_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [FRAME_W-1:0] frame_cnt_i,
    output logic               dma_req_o,
    input  logic               sample_wr_i,
    output logic               zero_frame_o,
    output logic               s1_start_o,
    input  logic               s1_release_i,
    input  logic               s1_done_i,
    output logic               s2_start_o,
    input  logic               s2_done_i,
    output logic               done_o
);
    localparam int JOB_W = FRAME_W + 1;
    localparam logic [JOB_W-1:0] JOB_ONE = JOB_W'(1);

    logic             run_q;
    logic             done_q;
    logic             s2_pend_q;
    logic             rel_seen_q;
    logic [JOB_W-1:0] last_job_q;
    logic [JOB_W-1:0] s1_next_q;
    logic [JOB_W-1:0] fill_job_q;
    logic [JOB_W-1:0] s2_fin_cnt_q;

    logic             fill_req;
    logic             fill_full;
    logic             s1_busy;
    logic             s2_busy;
    logic             s1_fin;
    logic             s2_fin;
    logic             start_go;
    logic             refill_go;
    logic             s1_launch;
    logic             s2_launch;
    logic             arm;
    fill_len_e        arm_len;

    // Decisions for this cycle, all taken from registered state.
    always_comb begin
        start_go  = start_i && !run_q;
        refill_go = run_q && s1_busy && s1_release_i && !rel_seen_q
                    && (s1_next_q <= last_job_q);
        s1_launch = run_q && fill_full && !s1_busy && !s2_pend_q
                    && (s1_next_q <= last_job_q);
        s2_launch = run_q && s2_pend_q && !s2_busy;
        arm       = start_go || refill_go;
        arm_len   = start_go ? FILL_LONG : FILL_SHORT;
    end

    pcm_fill_counter #(
        .FIRST_FILL (FIRST_FILL),
        .REFILL     (REFILL)
    ) i_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (arm),
        .len_i     (arm_len),
        .wr_i      (sample_wr_i),
        .consume_i (s1_launch),
        .req_o     (fill_req),
        .full_o    (fill_full)
    );

    pcm_stage_tracker i_stage1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (start_go),
        .launch_i (s1_launch),
        .done_i   (s1_done_i),
        .start_o  (s1_start_o),
        .busy_o   (s1_busy),
        .fin_o    (s1_fin)
    );

    pcm_stage_tracker i_stage2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (start_go),
        .launch_i (s2_launch),
        .done_i   (s2_done_i),
        .start_o  (s2_start_o),
        .busy_o   (s2_busy),
        .fin_o    (s2_fin)
    );

    // Stream state: running flag, latched last job index, drained flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            done_q     <= 1'b0;
            last_job_q <= '0;
        end else if (start_go) begin
            run_q      <= 1'b1;
            done_q     <= 1'b0;
            last_job_q <= {1'b0, frame_cnt_i};
        end else if (s2_fin && (s2_fin_cnt_q == last_job_q)) begin
            run_q      <= 1'b0;
            done_q     <= 1'b1;
        end
    end

    // First-stage job index and the one-release-per-job guard.
    always_ff @(posedge clk) begin
        if (!rst_n || start_go) begin
            s1_next_q  <= '0;
            rel_seen_q <= 1'b0;
        end else if (s1_launch) begin
            s1_next_q  <= s1_next_q + JOB_ONE;
            rel_seen_q <= 1'b0;
        end else if (s1_busy && s1_release_i) begin
            rel_seen_q <= 1'b1;
        end
    end

    // Job index of the fill in flight, used to mark the flush frame.
    always_ff @(posedge clk) begin
        if (!rst_n || start_go) begin
            fill_job_q <= '0;
        end else if (refill_go) begin
            fill_job_q <= s1_next_q;
        end
    end

    // Single-entry handoff between the stages.
    always_ff @(posedge clk) begin
        if (!rst_n || start_go) begin
            s2_pend_q <= 1'b0;
        end else if (s1_fin) begin
            s2_pend_q <= 1'b1;
        end else if (s2_launch) begin
            s2_pend_q <= 1'b0;
        end
    end

    // Count of second-stage completions within the stream.
    always_ff @(posedge clk) begin
        if (!rst_n || start_go) begin
            s2_fin_cnt_q <= '0;
        end else if (s2_fin) begin
            s2_fin_cnt_q <= s2_fin_cnt_q + JOB_ONE;
        end
    end

    assign dma_req_o    = fill_req;
    assign zero_frame_o = fill_req && (fill_job_q == last_job_q);
    assign done_o       = done_q;
endmodule

// File: rtl/pcm_fill_seq_chk.sv
// Protocol checker for pcm_fill_seq: tracks engine occupancy from the ports
// and checks the start and request ordering rules.
// Assumes: engines send one done per start and never a done while idle.
module pcm_fill_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic dma_req_o,
    input logic s1_start_o,
    input logic s1_done_i,
    input logic s2_start_o,
    input logic done_o
);
    logic       run_c;
    logic       s1_busy_c;
    logic [1:0] pend_c;

    // Observed stream, stage-1 occupancy and handoff count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_c     <= 1'b0;
            s1_busy_c <= 1'b0;
            pend_c    <= '0;
        end else begin
            if (start_i && !run_c) run_c <= 1'b1;
            else if (done_o)       run_c <= 1'b0;
            if (s1_start_o)        s1_busy_c <= 1'b1;
            else if (s1_done_i)    s1_busy_c <= 1'b0;
            if (s1_done_i && s1_busy_c && !s2_start_o) pend_c <= pend_c + 2'd1;
            else if (s2_start_o && !(s1_done_i && s1_busy_c)) pend_c <= pend_c - 2'd1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!dma_req_o && !s1_start_o && !s2_start_o && !done_o));

    a_r2_req_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !run_c) |=> dma_req_o);

    a_r4_s1_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        s1_start_o |=> !s1_start_o);

    a_r4_s1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        s1_start_o |-> (!s1_busy_c && !dma_req_o));

    a_r7_s2_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        s2_start_o |=> !s2_start_o);

    a_r7_s2_after_s1: assert property (@(posedge clk) disable iff (!rst_n)
        s2_start_o |-> (pend_c != 2'd0));

    a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    a_r10_idle_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!dma_req_o && !s1_start_o && !s2_start_o));
endmodule

bind pcm_fill_seq pcm_fill_seq_chk i_pcm_fill_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .dma_req_o  (dma_req_o),
    .s1_start_o (s1_start_o),
    .s1_done_i  (s1_done_i),
    .s2_start_o (s2_start_o),
    .done_o     (done_o)
);

// File: tb/test_pcm_fill_seq.sv
// Scoreboard bench: the stream driver queues the expected fills; a monitor
// pops them as each DMA request closes and compares length and zero marking.
module test_pcm_fill_seq;
    localparam int FIRST = 2048;
    localparam int REF   = 1024;
    localparam int FW    = 8;

    typedef struct {
        int size;
        bit zero;
    } fill_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [FW-1:0] frame_cnt = '0;
    logic          wr = 1'b0;
    logic          s1_rel = 1'b0;
    logic          s1_done = 1'b0;
    logic          s2_done = 1'b0;
    logic          req, zero, s1_start, s2_start, done;

    int    checks = 0;
    int    errors = 0;
    fill_t exp_q[$];
    int    acc = 0, s1_st = 0, s1_dn = 0, s2_st = 0, s2_dn = 0, fills_end = 0;
    bit    seen_zero = 0, overlap = 0, r3_flag = 0;
    bit    prev_req = 0, prev_s1 = 0, prev_s2 = 0;
    int    rel_dly = 10, s1_tail = 10, s2_dly = 10;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    pcm_fill_seq #(.FIRST_FILL(FIRST), .REFILL(REF), .FRAME_W(FW)) i_pcm_fill_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .frame_cnt_i(frame_cnt),
        .dma_req_o(req), .sample_wr_i(wr), .zero_frame_o(zero),
        .s1_start_o(s1_start), .s1_release_i(s1_rel), .s1_done_i(s1_done),
        .s2_start_o(s2_start), .s2_done_i(s2_done), .done_o(done));

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // DMA model: pseudo-random strobe, independent of the request (R12).
    initial forever begin
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        wr = lfsr[0] | lfsr[1];
    end

    // First-stage engine model: release, then done.
    initial forever begin
        @(negedge clk);
        if (s1_start) begin
            repeat (rel_dly) @(negedge clk);
            s1_rel = 1'b1;
            @(negedge clk) s1_rel = 1'b0;
            repeat (s1_tail) @(negedge clk);
            s1_done = 1'b1;
            @(negedge clk) s1_done = 1'b0;
        end
    end

    // Second-stage engine model: fixed latency, then done.
    initial forever begin
        @(negedge clk);
        if (s2_start) begin
            repeat (s2_dly) @(negedge clk);
            s2_done = 1'b1;
            @(negedge clk) s2_done = 1'b0;
        end
    end

    // Monitor: samples just after each edge and scores the observed behaviour.
    initial forever begin
        @(posedge clk);
        #1;
        if (rst_n) begin
            if (prev_req && wr) acc++;
            if (req && zero) seen_zero = 1;
            if (zero && !req) chk(0, "R9 zero marker without request", 1, 0);
            if (!prev_req && req && exp_q.size() == 0)
                chk(0, "R6 unexpected request", 1, 0);
            if (req && !r3_flag && exp_q.size() > 0 && acc >= exp_q[0].size) begin
                r3_flag = 1;
                chk(0, "R3 request held after last sample", acc, exp_q[0].size);
            end
            if (prev_req && !req && exp_q.size() > 0) begin
                fill_t f;
                f = exp_q.pop_front();
                chk(acc == f.size, "R2 R5 R12 fill length", acc, f.size);
                chk(seen_zero == f.zero, "R9 zero frame marking", int'(seen_zero), int'(f.zero));
                fills_end++;
                acc = 0;
                seen_zero = 0;
                r3_flag = 0;
            end
            if (s1_start) begin
                chk(!prev_s1, "R4 stage 1 pulse width", 2, 1);
                chk(fills_end > s1_st, "R4 fill complete before stage 1", fills_end, s1_st + 1);
                chk(s1_dn == s1_st, "R4 stage 1 idle at start", s1_dn, s1_st);
                chk(!req, "R4 no request at stage 1 start", int'(req), 0);
                chk(s2_st + 1 >= s1_dn, "R4 handoff empty at stage 1 start", s1_dn, s2_st);
                s1_st++;
            end
            if (s2_start) begin
                chk(!prev_s2, "R7 stage 2 pulse width", 2, 1);
                chk(s1_dn > s2_st, "R7 stage 2 after stage 1 result", s1_dn, s2_st + 1);
                chk(s2_dn == s2_st, "R7 stage 2 idle at start", s2_dn, s2_st);
                s2_st++;
            end
            if (s1_done) s1_dn++;
            if (s2_done) s2_dn++;
            if (s1_st > s1_dn && s2_st > s2_dn) overlap = 1;
        end
        prev_req = req;
        prev_s1  = s1_start;
        prev_s2  = s2_start;
    end

    // Driver: queue the expected fills, start a stream, and check the drain.
    task automatic run_stream(input int n, input int rd, input int td, input int sd,
                              input bit restart_mid, input bit want_overlap);
        rel_dly = rd; s1_tail = td; s2_dly = sd;
        s1_st = 0; s1_dn = 0; s2_st = 0; s2_dn = 0; fills_end = 0; overlap = 0;
        exp_q.push_back('{size: FIRST, zero: 1'b0});
        for (int j = 1; j <= n; j++) exp_q.push_back('{size: REF, zero: (j == n)});
        @(negedge clk);
        frame_cnt = FW'(n);
        start = 1'b1;
        @(posedge clk);
        #2;
        chk(req === 1'b1, "R2 request after start", int'(req), 1);
        chk(done === 1'b0, "R10 start clears done", int'(done), 0);
        @(negedge clk) start = 1'b0;
        if (restart_mid) begin
            repeat (300) @(negedge clk);
            frame_cnt = FW'(n + 3);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        for (int i = 0; i < 60000 && done !== 1'b1; i++) begin
            @(posedge clk);
            #2;
        end
        chk(done === 1'b1, "R10 done after flush frame", int'(done), 1);
        chk(s2_dn == n + 1, "R10 done after second stage of job N", s2_dn, n + 1);
        chk(exp_q.size() == 0, "R5 R11 all fills seen", exp_q.size(), 0);
        chk(fills_end == n + 1, "R6 fill count", fills_end, n + 1);
        chk(s1_st == n + 1, "R8 stage 1 starts", s1_st, n + 1);
        chk(s2_st == n + 1, "R8 stage 2 starts", s2_st, n + 1);
        if (want_overlap) chk(overlap, "R7 stages overlap", int'(overlap), 1);
        repeat (50) @(negedge clk);
        chk(done === 1'b1 && req === 1'b0, "R10 done holds, no request", int'(done), 1);
        chk(s1_st == n + 1 && s2_st == n + 1, "R6 R10 no starts after done", s1_st + s2_st, 2 * n + 2);
        exp_q.delete();
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Main sequence.
    initial begin
        repeat (4) @(negedge clk);
        chk(req === 1'b0 && zero === 1'b0, "R1 reset request/marker", int'(req), 0);
        chk(s1_start === 1'b0 && s2_start === 1'b0, "R1 reset starts", int'(s1_start), 0);
        chk(done === 1'b0, "R1 reset done", int'(done), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run_stream(1, 20, 40, 30, 1'b0, 1'b0);
        run_stream(3, 5, 200, 10, 1'b0, 1'b0);
        run_stream(2, 50, 30, 25, 1'b1, 1'b0);
        run_stream(4, 10, 20, 3000, 1'b0, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule